// File: doc/BRIEF.md
# Serial Interface Status Register with Read-Before-Clear Flags

This block is the 8-bit status register of a serial port. The CPU can read and write it. Five sticky status flags are set by single-cycle event inputs from the transmit and receive logic:

- transmit buffer empty
- receive buffer full
- overrun
- framing error
- parity error

A flag that has been set can only be cleared by software in two steps. First, a read must return that flag as 1. Second, a later write must put 0 in its bit position. Each flag tracks that read on its own, so reading a 1 from one flag does not allow another flag to be cleared.

The register also holds three other bits:

- A transmit-complete bit, which only hardware can change.
- A received multiprocessor bit, loaded from the receiver and read-only to software.
- A multiprocessor transmit bit, which software reads and writes freely.

Asynchronous reset and a synchronous standby input both load the same fixed value.

Top module: `sio_status_reg`

## Requirements
- R1: The read value is {txe, rxf, ovr, frm, par, tend, mpb, mpbt} from bit 7 down to bit 0. It is combinational from the register state.
- R2: Reset and a cycle with `stby` high both load 0x84, which sets txe and tend to 1 and all other bits to 0. Any earlier read of a flag as 1 is forgotten.
- R3: A CPU write never sets any of the five flags, whatever value it writes. Only the flag's own event input sets it, and the flag reads as 1 from the next cycle.
- R4: A flag clears on a write with 0 in its bit only if a read returned that flag as 1 before the write. Writing 1 to the bit neither clears the flag nor uses up that read.
- R5: If a flag's event input fires again after the read, the read no longer counts, and a following 0 write leaves the flag at 1.
- R6: When a flag's event and a valid clearing write arrive in the same cycle, the flag stays 1.
- R7: The tend bit (bit 2) is set by `tend_set` and cleared by `tend_clr`; `tend_set` wins when both are high. CPU writes never change it.
- R8: The mpb bit (bit 1) takes `mpb_bit` in a cycle with `mpb_vld` high. CPU writes never change it.
- R9: The mpbt bit (bit 0) takes `wdata[0]` on every write.
- R10: A read that returns a flag as 0 does not allow that flag to be cleared after a later event sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stby | input | 1 | Synchronous reload of the reset value |
| rd_en | input | 1 | CPU read strobe, one cycle |
| wr_en | input | 1 | CPU write strobe, one cycle |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Register contents |
| txe_set | input | 1 | Transmit data moved into the shift register |
| rxf_set | input | 1 | Received byte ready |
| ovr_set | input | 1 | Receive overrun detected |
| frm_set | input | 1 | Framing error detected |
| par_set | input | 1 | Parity error detected |
| tend_set | input | 1 | Transmission finished |
| tend_clr | input | 1 | Transmission restarted |
| mpb_vld | input | 1 | Load the received multiprocessor bit |
| mpb_bit | input | 1 | Received multiprocessor bit value |

## Verification
The assertions allow event inputs, writes and standby to arrive in any combination, including all in the same cycle. The one assumption is that the inputs are stable at the clock edge. Every property therefore compares the register only with the cycle before it.

The bench changes every input on the falling edge and reads `rdata` just before the next rising edge. Each event pulse and each CPU access lasts exactly one cycle. Collisions, such as an event arriving together with a write, are created on purpose in a single cycle.

// File: rtl/sio_status_reg.sv
module sio_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       txe_set,
  input  logic       rxf_set,
  input  logic       ovr_set,
  input  logic       frm_set,
  input  logic       par_set,
  input  logic       tend_set,
  input  logic       tend_clr,
  input  logic       mpb_vld,
  input  logic       mpb_bit
);
  localparam int        NFLAG   = 5;
  localparam logic [7:0] INIT_VAL = 8'h84;

  logic [NFLAG-1:0] flag_q, arm_q;
  logic             tend_q, mpb_q, mpbt_q;

  wire [NFLAG-1:0] hw_set  = {txe_set, rxf_set, ovr_set, frm_set, par_set};
  wire [NFLAG-1:0] zero_wr = {NFLAG{wr_en}} & ~wdata[7:8-NFLAG];
  wire [NFLAG-1:0] seen_hi = {NFLAG{rd_en}} & flag_q;
  wire [NFLAG-1:0] clr_ok  = zero_wr & arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {flag_q, tend_q, mpb_q, mpbt_q} <= INIT_VAL;
      arm_q <= '0;
    end else if (stby) begin
      {flag_q, tend_q, mpb_q, mpbt_q} <= INIT_VAL;
      arm_q <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_ok) | hw_set;
      arm_q  <= ~hw_set & ((arm_q & ~zero_wr) | seen_hi);
      if (tend_set)      tend_q <= 1'b1;
      else if (tend_clr) tend_q <= 1'b0;
      if (mpb_vld) mpb_q  <= mpb_bit;
      if (wr_en)   mpbt_q <= wdata[0];
    end
  end

  assign rdata = {flag_q, tend_q, mpb_q, mpbt_q};
endmodule

// File: rtl/sio_status_chk.sv
module sio_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stby,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [4:0] ev,
  input logic       tend_set,
  input logic       tend_clr,
  input logic       mpb_vld,
  input logic       mpb_bit
);
  a_r2_standby_value: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> (rdata == 8'h84));

  a_r3_no_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !stby |=> ((rdata[7:3] & ~$past(rdata[7:3]) & ~$past(ev)) == 5'b0));

  a_r4_clear_needs_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    !stby |=> ((~rdata[7:3] & $past(rdata[7:3]) & ~$past({5{wr_en}} & ~wdata[7:3])) == 5'b0));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !stby |=> ((rdata[7:3] & $past(ev)) == $past(ev)));

  a_r7_tend_hw_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby && !tend_set && !tend_clr) |=> $stable(rdata[2]));

  a_r8_mpb_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby && mpb_vld) |=> (rdata[1] == $past(mpb_bit)));

  a_r9_mpbt_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby && wr_en) |=> (rdata[0] == $past(wdata[0])));
endmodule

bind sio_status_reg sio_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stby(stby), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .ev({txe_set, rxf_set, ovr_set, frm_set, par_set}),
  .tend_set(tend_set), .tend_clr(tend_clr), .mpb_vld(mpb_vld), .mpb_bit(mpb_bit)
);

// File: tb/sim_sio_status_reg.sv
module sim_sio_status_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0, stby = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic txe_set = 0, rxf_set = 0, ovr_set = 0, frm_set = 0, par_set = 0;
  logic tend_set = 0, tend_clr = 0, mpb_vld = 0, mpb_bit = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sio_status_reg u0 (.*);

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic chk(input [7:0] exp, input string req);
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata=%02h expected %02h", req, rdata, exp);
    end
  endtask

  task automatic rd; rd_en = 1; tick(); rd_en = 0; endtask
  task automatic wr(input [7:0] d); wr_en = 1; wdata = d; tick(); wr_en = 0; endtask
  task automatic ev(input [4:0] v);
    {txe_set, rxf_set, ovr_set, frm_set, par_set} = v; tick();
    {txe_set, rxf_set, ovr_set, frm_set, par_set} = 5'b0;
  endtask

  task automatic t_reset; chk(8'h84, "R1 R2 reset"); endtask

  task automatic t_write_one;
    wr(8'hFF); chk(8'h85, "R3 R9 write ones");
    wr(8'h00); chk(8'h84, "R4 R7 unread zero write");
  endtask

  task automatic t_read_clear;
    ev(5'b01000); chk(8'hC4, "R3 rxf event");
    rd();
    wr(8'hBC); chk(8'h84, "R4 clear rxf");
    wr(8'h7C); chk(8'h04, "R4 txe arm kept across 1 write");
    ev(5'b10000); chk(8'h84, "R3 txe event");
  endtask

  task automatic t_rearm;
    ev(5'b00100); chk(8'hA4, "R3 ovr event");
    rd(); ev(5'b00100);
    wr(8'hDC); chk(8'hA4, "R5 second event voids read");
    rd(); wr(8'hDC); chk(8'h84, "R5 clear after new read");
  endtask

  task automatic t_zero_read;
    rd(); ev(5'b00010); chk(8'h94, "R10 frm event");
    wr(8'hEC); chk(8'h94, "R10 read of 0 does not arm");
    rd(); wr(8'hEC); chk(8'h84, "R4 clear frm");
  endtask

  task automatic t_set_wins;
    ev(5'b00001); chk(8'h8C, "R3 par event");
    rd();
    par_set = 1; wr(8'hF4); par_set = 0; chk(8'h8C, "R6 set beats clear");
    wr(8'hF4); chk(8'h8C, "R6 arm lost on collision");
    rd(); wr(8'hF4); chk(8'h84, "R4 clear par");
  endtask

  task automatic t_tend;
    tend_clr = 1; tick(); tend_clr = 0; chk(8'h80, "R7 tend clear");
    wr(8'hFF); chk(8'h81, "R7 write cannot set tend");
    tend_set = 1; tend_clr = 1; tick(); tend_set = 0; tend_clr = 0;
    chk(8'h85, "R7 set wins over clr");
    wr(8'hF8); chk(8'h84, "R7 write cannot clear tend");
  endtask

  task automatic t_mpb;
    mpb_vld = 1; mpb_bit = 1; tick(); mpb_vld = 0; chk(8'h86, "R8 mpb load");
    wr(8'hF8); chk(8'h86, "R8 write ignored");
    mpb_vld = 1; mpb_bit = 0; tick(); mpb_vld = 0; chk(8'h84, "R8 mpb load 0");
  endtask

  task automatic t_stby;
    ev(5'b01100); wr(8'hFF); chk(8'hE5, "R3 two events");
    rd();
    stby = 1; rxf_set = 1; tick(); stby = 0; rxf_set = 0; chk(8'h84, "R2 standby reload");
    wr(8'h00); chk(8'h84, "R2 standby drops arm");
    rd(); wr(8'h00); chk(8'h04, "R4 txe clear after read");
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset(); t_write_one(); t_read_clear(); t_rearm(); t_zero_read();
    t_set_wins(); t_tend(); t_mpb(); t_stby();
    finish_up();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule